// File: doc/BRIEF.md
# Reset Source Sequencing Controller

This block is the reset generator of a small microcontroller. It watches two digital comparator outputs: one says the supply is above the power-on level, the other says it is above the lower power-fail level. It also takes three reset requests: an external pin, a watchdog and a software request. From these it drives one active-low system reset. It records the cause of the last reset in a flag register. A monitor-disable bit controls whether the power-fail comparator may cause a reset. Both registers sit behind a small register read/write port.

Both comparator inputs pass through a two-flop synchronizer. The reset output is asserted at once by the block's own asynchronous reset, and is otherwise set and released only on clock edges. The power-on release delay is a parameter counted in clock cycles.

A cold start loads the power-on flag alone and enables the monitor. A cold start is either a power-on or power-fail event, or any request made while the monitor is disabled. A request made while the monitor is enabled clears the power-on flag and records its own source bit instead.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While rst_ni is low, sys_rst_no is low, the source register reads 0x02 and the monitor-disable bit is 0.
- R2: While the power-on comparator input is low, sys_rst_no stays low, whatever the other inputs do.
- R3: When por_ok_i rises, sys_rst_no rises at the (POR_DLY_CYC+3)th clock edge. That is two synchronizer edges, one edge to enter the delay, and POR_DLY_CYC delay edges.
- R4: After a power-on reset, the source register (address 0) reads 0x02: bit 1, the power-on flag, is 1 and all other bits are 0.
- R5: With the monitor enabled, a low pfail_ok_i drives sys_rst_no low at the 3rd edge. When the input is restored, sys_rst_no goes high at the 3rd edge with no further delay. The source register then reads 0x02.
- R6: With the monitor enabled, a request drives sys_rst_no low at the next edge. The reset is held while any request is high and released at the first edge after all requests are low. The source register then has bit 1 cleared and holds bit 0 for the pin, bit 2 for the watchdog and bit 3 for software, OR-ed over the whole reset.
- R7: Writing 1 to bit 5 of address 1 disables the supply monitor. Address 1 then reads 0x20. While the monitor is disabled, a low pfail_ok_i has no effect on sys_rst_no.
- R8: With the monitor disabled, any request gives a full power-on reset. The reset is held while the request is high and released at the (POR_DLY_CYC+1)th edge after the request drops. The source register then reads 0x02.
- R9: Every power-on, power-fail or monitor-disabled reset clears the monitor-disable bit. The bit is 0 whenever sys_rst_no is low.
- R10: Writes made while sys_rst_no is low are ignored. Writes to address 0 are always ignored.
- R11: reg_rdata_o is registered: it shows the register at reg_addr_i as it stood before the clock edge. Addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller itself |
| por_ok_i | input | 1 | Supply above power-on level (asynchronous) |
| pfail_ok_i | input | 1 | Supply above power-fail level (asynchronous) |
| pin_rst_i | input | 1 | External pin reset request, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous, active high |
| sw_rst_i | input | 1 | Software reset request, synchronous, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address: 0 = source flags, 1 = power mode |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The bench drives a cold power-up, then a power-fail dip and its recovery. It then sends each request alone and a pin request that overlaps a watchdog request. These tell the delayed release apart from the immediate one, and show whether source bits are loaded or merged. The same pin request is repeated with the monitor disabled, to tell a plain request reset from a full power-on reset with its delay and its flag value. Writes are tried during reset and to the read-only address. A power-fail dip is tried with the monitor off, which must leave the reset high. A power-on dip is made while the monitor is disabled. A behavioural model runs alongside and compares the reset output and the read data on every clock.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {ST_OFF, ST_DLY, ST_PF, ST_REQ, ST_RUN} seq_state_e;

  localparam int REG_W      = 8;
  localparam int N_REQ      = 3;
  localparam int REQ_PIN    = 0;
  localparam int REQ_WDT    = 1;
  localparam int REQ_SW     = 2;
  localparam int FLAG_PIN   = 0;
  localparam int FLAG_POR   = 1;
  localparam int FLAG_WDT   = 2;
  localparam int FLAG_SW    = 3;
  localparam int MONDIS_BIT = 5;
  localparam int ADDR_SRC   = 0;
  localparam int ADDR_PMODE = 1;
  localparam logic [REG_W-1:0] POR_MASK = REG_W'(1) << FLAG_POR;

  typedef struct packed {
    logic cold;   // load power-on flag, re-enable monitor
    logic load;   // replace flags with request sources
    logic merge;  // OR request sources into flags
    logic wr_ok;  // register writes allowed
  } reg_ctl_t;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm import rst_seq_pkg::*; #(
  parameter int POR_DLY_CYC = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ok_i,
  input  logic             pf_ok_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic             mon_dis_i,
  output reg_ctl_t         ctl_o,
  output logic             rst_no
);
  localparam int CNT_W = (POR_DLY_CYC > 1) ? $clog2(POR_DLY_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_DLY_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             rst_q;
  logic             any_req;

  assign any_req = |req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    ctl_o   = '0;
    if (!por_ok_i) begin
      state_d    = ST_OFF;
      full_d     = 1'b0;
      ctl_o.cold = 1'b1;
    end else if (!mon_dis_i && !pf_ok_i) begin
      state_d    = ST_PF;
      full_d     = 1'b0;
      ctl_o.cold = 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_DLY;
          cnt_d   = '0;
        end
        ST_DLY: begin
          if (cnt_q == CNT_LAST) state_d = ST_RUN;
          else                   cnt_d   = cnt_q + CNT_W'(1);
        end
        ST_PF: state_d = ST_RUN;
        ST_REQ: begin
          if (any_req) begin
            ctl_o.merge = !full_q;
          end else if (full_q) begin
            state_d = ST_DLY;
            cnt_d   = '0;
            full_d  = 1'b0;
          end else begin
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (any_req) begin
            state_d = ST_REQ;
            if (mon_dis_i) begin
              ctl_o.cold = 1'b1;
              full_d     = 1'b1;
            end else begin
              ctl_o.load = 1'b1;
            end
          end else begin
            ctl_o.wr_ok = 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      rst_q   <= (state_d != ST_RUN);
    end
  end

  assign rst_no = !rst_q;
endmodule

// File: rtl/rst_seq_regs.sv
module rst_seq_regs import rst_seq_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_ctl_t          ctl_i,
  input  logic [N_REQ-1:0]  src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  flags_o,
  output logic              mon_dis_o
);
  logic [REG_W-1:0] flags_q, src_flags, pmode_view, rd_d, rdata_q;
  logic             mon_q;
  logic             pmode_hit;
  wire              unused_wdata = ^wdata_i;

  always_comb begin
    src_flags           = '0;
    src_flags[FLAG_PIN] = src_i[REQ_PIN];
    src_flags[FLAG_WDT] = src_i[REQ_WDT];
    src_flags[FLAG_SW]  = src_i[REQ_SW];
  end

  assign pmode_view = REG_W'(mon_q) << MONDIS_BIT;
  assign pmode_hit  = (addr_i == ADDR_W'(ADDR_PMODE));

  always_comb begin
    if (addr_i == ADDR_W'(ADDR_SRC)) rd_d = flags_q;
    else if (pmode_hit)              rd_d = pmode_view;
    else                             rd_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= POR_MASK;
      mon_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_d;
      if (ctl_i.cold) begin
        flags_q <= POR_MASK;
        mon_q   <= 1'b0;
      end else if (ctl_i.load) begin
        flags_q <= src_flags;
      end else if (ctl_i.merge) begin
        flags_q <= flags_q | src_flags;
      end else if (ctl_i.wr_ok && we_i && pmode_hit) begin
        mon_q <= wdata_i[MONDIS_BIT];
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign flags_o   = flags_q;
  assign mon_dis_o = mon_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl import rst_seq_pkg::*; #(
  parameter int POR_DLY_CYC = 1000000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ok_i,
  input  logic              pfail_ok_i,
  input  logic              pin_rst_i,
  input  logic              wdt_rst_i,
  input  logic              sw_rst_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              sys_rst_no
);
  logic [1:0]       cmp_s;
  logic [N_REQ-1:0] req;
  reg_ctl_t         ctl;
  logic             mon_dis;
  logic [REG_W-1:0] flags;

  always_comb begin
    req          = '0;
    req[REQ_PIN] = pin_rst_i;
    req[REQ_WDT] = wdt_rst_i;
    req[REQ_SW]  = sw_rst_i;
  end

  rst_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pfail_ok_i, por_ok_i}),
    .q_o   (cmp_s)
  );

  rst_seq_fsm #(.POR_DLY_CYC(POR_DLY_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_ok_i (cmp_s[0]),
    .pf_ok_i  (cmp_s[1]),
    .req_i    (req),
    .mon_dis_i(mon_dis),
    .ctl_o    (ctl),
    .rst_no   (sys_rst_no)
  );

  rst_seq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .src_i    (req),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .flags_o  (flags),
    .mon_dis_o(mon_dis)
  );
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk import rst_seq_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ok_i,
  input logic             pfail_ok_i,
  input logic             pin_rst_i,
  input logic             wdt_rst_i,
  input logic             sw_rst_i,
  input logic             reg_we_i,
  input logic             sys_rst_no,
  input logic             mon_dis_i,
  input logic [REG_W-1:0] flags_i
);
  AST_POR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!por_ok_i, 2) |=> !sys_rst_no); // R2

  AST_PF_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!pfail_ok_i, 2) && !mon_dis_i) |=> !sys_rst_no); // R5

  AST_REQ_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && (pin_rst_i || wdt_rst_i || sw_rst_i)) |=> !sys_rst_no); // R6

  AST_PORFLAG_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[FLAG_POR] |-> ((flags_i & ~POR_MASK) == '0)); // R4

  AST_MON_ON_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !mon_dis_i); // R9

  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && reg_we_i) |=> $stable(mon_dis_i)); // R10
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_ok_i  (por_ok_i),
  .pfail_ok_i(pfail_ok_i),
  .pin_rst_i (pin_rst_i),
  .wdt_rst_i (wdt_rst_i),
  .sw_rst_i  (sw_rst_i),
  .reg_we_i  (reg_we_i),
  .sys_rst_no(sys_rst_no),
  .mon_dis_i (mon_dis),
  .flags_i   (flags)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
  localparam int D = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_ok_i = 1'b0, pfail_ok_i = 1'b0;
  logic       pin_rst_i = 1'b0, wdt_rst_i = 1'b0, sw_rst_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       sys_rst_no;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.POR_DLY_CYC(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_ok_i(por_ok_i), .pfail_ok_i(pfail_ok_i),
    .pin_rst_i(pin_rst_i), .wdt_rst_i(wdt_rst_i), .sw_rst_i(sw_rst_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .sys_rst_no(sys_rst_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 off, 1 delay, 2 power-fail, 3 request, 4 running
  int       m_ph, m_cnt;
  bit       m_full, m_mon, m_rst;
  bit [7:0] m_flags, m_rd, m_src;
  bit [1:0] m_por, m_pf;
  bit       m_ps, m_fs, m_any;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_full = 0; m_mon = 0; m_rst = 1;
      m_flags = 8'h02; m_rd = 0; m_por = 0; m_pf = 0;
    end else begin
      m_ps = m_por[1]; m_fs = m_pf[1];
      m_por = {m_por[0], por_ok_i};
      m_pf  = {m_pf[0], pfail_ok_i};
      m_src = {4'b0, sw_rst_i, wdt_rst_i, 1'b0, pin_rst_i};
      m_any = pin_rst_i | wdt_rst_i | sw_rst_i;
      m_rd = (reg_addr_i == 0) ? m_flags : (reg_addr_i == 1) ? {2'b0, m_mon, 5'b0} : 8'h00;
      if (!m_ps) begin
        m_ph = 0; m_full = 0; m_flags = 8'h02; m_mon = 0;
      end else if (!m_mon && !m_fs) begin
        m_ph = 2; m_full = 0; m_flags = 8'h02; m_mon = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (m_cnt == D - 1) m_ph = 4; else m_cnt++;
      end else if (m_ph == 2) begin
        m_ph = 4;
      end else if (m_ph == 3) begin
        if (m_any) begin
          if (!m_full) m_flags |= m_src;
        end else if (m_full) begin
          m_ph = 1; m_cnt = 0; m_full = 0;
        end else m_ph = 4;
      end else begin
        if (m_any) begin
          m_ph = 3;
          if (m_mon) begin m_flags = 8'h02; m_mon = 0; m_full = 1; end
          else m_flags = m_src;
        end else if (reg_we_i && reg_addr_i == 1) begin
          m_mon = reg_wdata_i[5];
        end
      end
      m_rst = (m_ph != 4);
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2 R3 R5 R6 R8 model sys_rst_no", int'(sys_rst_no), int'(!m_rst));
      chk("R11 model reg_rdata_o", int'(reg_rdata_o), int'(m_rd));
    end
  end

  task automatic edges_to(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
    end while (sys_rst_no !== lvl && n < 500);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr_i = 2'(a);
    @(negedge clk); v = int'(reg_rdata_o);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we_i = 1; reg_addr_i = 2'(a); reg_wdata_i = 8'(d);
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n, v;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst_no in reset", int'(sys_rst_no), 0);
    @(negedge clk); rst_ni = 1;
    rd(0, v); chk("R1 flags after reset", v, 8'h02);
    rd(1, v); chk("R1 monitor bit after reset", v, 0);
    // R2: request while supply low has no effect
    pin_rst_i = 1; repeat (4) @(negedge clk);
    chk("R2 held with supply low", int'(sys_rst_no), 0);
    pin_rst_i = 0; repeat (2) @(negedge clk);
    // R3 power-up
    @(negedge clk); por_ok_i = 1; pfail_ok_i = 1;
    edges_to(1'b1, n); chk("R3 power-on release edges", n, D + 3);
    rd(0, v); chk("R4 flags after power-on", v, 8'h02);
    rd(1, v); chk("R9 monitor enabled after power-on", v, 0);
    rd(2, v); chk("R11 unmapped address", v, 0);
    // R5 brown-out
    @(negedge clk); pfail_ok_i = 0;
    edges_to(1'b0, n); chk("R5 power-fail assert edges", n, 3);
    repeat (5) @(negedge clk);
    pfail_ok_i = 1;
    edges_to(1'b1, n); chk("R5 power-fail release edges", n, 3);
    rd(0, v); chk("R5 flags after power-fail", v, 8'h02);
    // R6 single requests
    @(negedge clk); pin_rst_i = 1;
    edges_to(1'b0, n); chk("R6 pin assert edges", n, 1);
    repeat (3) @(negedge clk);
    pin_rst_i = 0;
    edges_to(1'b1, n); chk("R6 pin release edges", n, 1);
    rd(0, v); chk("R6 pin flags", v, 8'h01);
    @(negedge clk); wdt_rst_i = 1; @(negedge clk); wdt_rst_i = 0;
    repeat (2) @(negedge clk);
    rd(0, v); chk("R6 watchdog flags", v, 8'h04);
    @(negedge clk); sw_rst_i = 1; @(negedge clk); sw_rst_i = 0;
    repeat (2) @(negedge clk);
    rd(0, v); chk("R6 software flags", v, 8'h08);
    // R6 overlap: pin then watchdog
    @(negedge clk); pin_rst_i = 1;
    repeat (2) @(negedge clk); wdt_rst_i = 1;
    repeat (2) @(negedge clk); pin_rst_i = 0;
    repeat (2) @(negedge clk);
    chk("R6 held by second request", int'(sys_rst_no), 0);
    wdt_rst_i = 0; repeat (2) @(negedge clk);
    rd(0, v); chk("R6 merged flags", v, 8'h05);
    // R10 write to flag address ignored
    wr(0, 8'hFF);
    rd(0, v); chk("R10 flag write ignored", v, 8'h05);
    // R7 disable monitor
    wr(1, 8'h20);
    rd(1, v); chk("R7 monitor disable readback", v, 8'h20);
    @(negedge clk); pfail_ok_i = 0;
    repeat (8) @(negedge clk);
    chk("R7 power-fail ignored when disabled", int'(sys_rst_no), 1);
    pfail_ok_i = 1; repeat (4) @(negedge clk);
    // R8 pin request with monitor disabled
    @(negedge clk); pin_rst_i = 1;
    edges_to(1'b0, n); chk("R8 disabled pin assert edges", n, 1);
    repeat (3) @(negedge clk);
    pin_rst_i = 0;
    edges_to(1'b1, n); chk("R8 full power-on release edges", n, D + 1);
    rd(0, v); chk("R8 flags after full power-on", v, 8'h02);
    rd(1, v); chk("R9 monitor re-enabled", v, 0);
    // R10 write during reset ignored
    @(negedge clk); sw_rst_i = 1;
    wr(1, 8'h20);
    @(negedge clk); sw_rst_i = 0;
    repeat (2) @(negedge clk);
    rd(1, v); chk("R10 write during reset ignored", v, 0);
    // R9 power-on dip while disabled
    wr(1, 8'h20);
    rd(1, v); chk("R7 disable before power dip", v, 8'h20);
    @(negedge clk); por_ok_i = 0;
    edges_to(1'b0, n); chk("R2 power dip assert edges", n, 3);
    repeat (4) @(negedge clk);
    por_ok_i = 1;
    edges_to(1'b1, n); chk("R3 power dip release edges", n, D + 3);
    rd(1, v); chk("R9 monitor enabled after power dip", v, 0);
    rd(0, v); chk("R4 flags after power dip", v, 8'h02);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule